// File: doc/BRIEF.md
# Memory and Port Address Decoder

This block sits between an 8-bit processor bus and the things that bus can reach. For memory cycles it steers the 16-bit address either to an installed RAM or to a 256-byte boot ROM that covers the top page of the address space. For I/O cycles it turns the port number (the low address byte) into a one-hot select for a disk controller or one of two serial channels, plus a small register index inside that device. It also answers some reads by itself. An installed-size miss returns a fill byte of 0xFF. An unmapped port also returns 0xFF. A dedicated switch port returns the high byte of a 16-bit front-panel switch word.

RAM, ROM and device registers are read asynchronously: they present data in the same cycle as the strobe. The decoder captures the selected byte at the clock edge that ends the strobe cycle. It presents the byte for one cycle as `rd_data` with the `rd_valid` pulse. The return path has no ready signal and cannot be stalled. The requester must take the byte in the cycle `rd_valid` is high. Only one of the four strobes may be high in a cycle. Writes produce no return. The RAM size is the parameter `RAM_BYTES`. It must be a nonzero multiple of 4096 and at most 65536.

Top module: `bus_decoder`

## Requirements
- R1: During and directly after reset, `rd_valid` is 0, `rd_data` is 0x00, `dev_sel` is 0 and `ram_we` is 0.
- R2: A memory read below `RAM_BYTES` and outside the ROM window returns `ram_rdata` for address `ram_addr` = the address's low bits. The byte comes with a one-cycle `rd_valid` pulse, one cycle after the strobe.
- R3: A memory read at or above `RAM_BYTES`, and below 0xFF00, returns 0xFF.
- R4: A memory read in 0xFF00..0xFFFF returns `rom_rdata` with `rom_addr` = address bits 7:0. This holds even when the RAM covers that range.
- R5: A memory write in 0xFF00..0xFFFF never raises `ram_we`.
- R6: A memory write below `RAM_BYTES` and outside the ROM window raises `ram_we` in the strobe cycle, with `ram_addr` and `ram_wdata` taken from the bus. A write at or above `RAM_BYTES` leaves `ram_we` low.
- R7: An input from port 0xFF returns `sw_in[15:8]`.
- R8: An input from a port with no device returns 0xFF and raises no `dev_sel` bit. An output to such a port, including 0xFF, raises no `dev_sel` bit and no `dev_wr`.
- R9: Ports 8, 9 and 10 raise `dev_sel[0]` (disk) with `dev_idx` 0, 1 and 2. Port 11 is unmapped.
- R10: Ports 16 and 17 raise `dev_sel[1]` (serial 0), and ports 18 and 19 raise `dev_sel[2]` (serial 1). `dev_idx` is the offset from the channel's first port (0 = status, 1 = data). Exactly one select bit is high for each strobe that reaches a device, and none without a strobe.
- R11: `dev_rd` or `dev_wr` follows the strobe for a mapped port. An input returns the selected device's read byte one cycle later.
- R12: A write never produces `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Bus address; bits 7:0 are the port number in I/O cycles |
| cpu_wdata | input | 8 | Bus write data |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_rd | input | 1 | Port input strobe |
| io_wr | input | 1 | Port output strobe |
| rd_valid | output | 1 | Read return valid, one cycle after a read strobe |
| rd_data | output | 8 | Read return byte |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM asynchronous read data |
| rom_addr | output | 8 | Boot ROM byte offset |
| rom_rdata | input | 8 | Boot ROM asynchronous read data |
| sw_in | input | 16 | Front-panel switch word |
| dev_sel | output | 3 | One-hot select: bit0 disk, bit1 serial 0, bit2 serial 1 |
| dev_idx | output | 2 | Register index inside the selected device |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | 8 | Device write data |
| disk_rdata | input | 8 | Disk controller read data |
| ser0_rdata | input | 8 | Serial channel 0 read data |
| ser1_rdata | input | 8 | Serial channel 1 read data |

## Verification
The returned-byte path shows a wrong source choice or a stale return register at the port one cycle after the read strobe. It appears as a mismatched byte or as a `rd_valid` pulse that has no read behind it. The select path is combinational: a wrong base, range or index shows on `dev_sel`/`dev_idx` inside the strobe cycle itself. The bench checks those signals before the edge. Window priority is tested with addresses on both sides of each boundary: below and at the installed size, and just below and at 0xFF00. These are the points where a comparison off by one would show.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  // where a read return byte comes from
  typedef enum logic [2:0] {
    SRC_FILL   = 3'd0,
    SRC_RAM    = 3'd1,
    SRC_ROM    = 3'd2,
    SRC_SWITCH = 3'd3,
    SRC_DEV    = 3'd4
  } rd_src_e;

  localparam int DEV_N    = 3;
  localparam int IDX_W    = 2;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/bdec_mem_map.sv
module bdec_mem_map
  import bdec_pkg::*;
#(
  parameter int RAM_BYTES = 16384,
  parameter int ROM_BASE  = 'hFF00,
  parameter int ROM_BYTES = 256,
  localparam int RAM_AW   = $clog2(RAM_BYTES),
  localparam int ROM_AW   = $clog2(ROM_BYTES)
) (
  input  logic [15:0]       addr,
  input  logic              wr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_we,
  output logic [ROM_AW-1:0] rom_addr,
  output rd_src_e           src
);
  logic in_ram, in_rom;

  assign in_ram   = 32'(addr) < RAM_BYTES;
  assign in_rom   = 32'(addr) >= ROM_BASE;
  assign ram_addr = addr[RAM_AW-1:0];
  assign rom_addr = addr[ROM_AW-1:0];
  // ROM window hides RAM for both directions
  assign ram_we   = wr & in_ram & ~in_rom;

  always_comb begin
    if (in_rom)      src = SRC_ROM;
    else if (in_ram) src = SRC_RAM;
    else             src = SRC_FILL;
  end
endmodule

// File: rtl/bdec_port_map.sv
module bdec_port_map
  import bdec_pkg::*;
#(
  parameter int DISK_PORT = 8,
  parameter int DISK_CNT  = 3,
  parameter int SER0_PORT = 16,
  parameter int SER1_PORT = 18,
  parameter int SER_CNT   = 2,
  parameter int SW_PORT   = 'hFF
) (
  input  logic [7:0]       port,
  input  logic             rd,
  input  logic             wr,
  output logic [DEV_N-1:0] dev_sel,
  output logic [IDX_W-1:0] dev_idx,
  output logic             dev_rd,
  output logic             dev_wr,
  output rd_src_e          src
);
  function automatic int dev_base(int g);
    case (g)
      0:       return DISK_PORT;
      1:       return SER0_PORT;
      default: return SER1_PORT;
    endcase
  endfunction

  function automatic int dev_cnt(int g);
    return (g == 0) ? DISK_CNT : SER_CNT;
  endfunction

  logic [DEV_N-1:0] match;
  logic [IDX_W-1:0] offs [DEV_N];
  logic             hit;

  for (genvar g = 0; g < DEV_N; g++) begin : g_dev
    localparam int B = dev_base(g);
    localparam int N = dev_cnt(g);
    logic [7:0] diff;
    assign match[g] = (32'(port) >= B) && (32'(port) < B + N);
    assign diff     = port - 8'(B);
    assign offs[g]  = diff[IDX_W-1:0];
  end

  always_comb begin
    dev_idx = '0;
    for (int g = 0; g < DEV_N; g++)
      if (match[g]) dev_idx = dev_idx | offs[g];
  end

  assign hit     = |match;
  assign dev_sel = match & {DEV_N{rd | wr}};
  assign dev_rd  = rd & hit;
  assign dev_wr  = wr & hit;

  always_comb begin
    if (hit)                      src = SRC_DEV;
    else if (32'(port) == SW_PORT) src = SRC_SWITCH;
    else                          src = SRC_FILL;
  end
endmodule

// File: rtl/bdec_rd_return.sv
module bdec_rd_return
  import bdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_rd,
  input  logic       io_rd,
  input  rd_src_e    mem_src,
  input  rd_src_e    io_src,
  input  logic [7:0] ram_rdata,
  input  logic [7:0] rom_rdata,
  input  logic [7:0] sw_hi,
  input  logic [7:0] dev_rdata,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  rd_src_e    src;
  logic [7:0] pick;

  assign src = mem_rd ? mem_src : io_src;

  always_comb begin
    case (src)
      SRC_RAM:    pick = ram_rdata;
      SRC_ROM:    pick = rom_rdata;
      SRC_SWITCH: pick = sw_hi;
      SRC_DEV:    pick = dev_rdata;
      default:    pick = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= mem_rd | io_rd;
      if (mem_rd | io_rd) rd_data <= pick;
    end
  end

  // R2: the return pulse lasts exactly one cycle per single read
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(mem_rd | io_rd, 2)) |=> !rd_valid || $past(mem_rd | io_rd));
endmodule

// File: rtl/bus_decoder.sv
module bus_decoder
  import bdec_pkg::*;
#(
  parameter int RAM_BYTES = 16384,
  parameter int DISK_PORT = 8,
  parameter int SER0_PORT = 16,
  parameter int SER1_PORT = 18,
  parameter int SW_PORT   = 'hFF,
  localparam int RAM_AW   = $clog2(RAM_BYTES),
  localparam int ROM_BASE = 'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ram_we,
  input  logic [7:0]        ram_rdata,
  output logic [7:0]        rom_addr,
  input  logic [7:0]        rom_rdata,
  input  logic [15:0]       sw_in,
  output logic [2:0]        dev_sel,
  output logic [1:0]        dev_idx,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        disk_rdata,
  input  logic [7:0]        ser0_rdata,
  input  logic [7:0]        ser1_rdata
);
  rd_src_e    mem_src, io_src;
  logic [7:0] dev_rdata;
  logic [7:0] dev_arr [DEV_N];

  bdec_mem_map #(.RAM_BYTES(RAM_BYTES), .ROM_BASE(ROM_BASE), .ROM_BYTES(256)) u_mem (
    .addr(cpu_addr), .wr(mem_wr), .ram_addr(ram_addr), .ram_we(ram_we),
    .rom_addr(rom_addr), .src(mem_src));

  bdec_port_map #(.DISK_PORT(DISK_PORT), .DISK_CNT(3), .SER0_PORT(SER0_PORT),
                  .SER1_PORT(SER1_PORT), .SER_CNT(2), .SW_PORT(SW_PORT)) u_port (
    .port(cpu_addr[7:0]), .rd(io_rd), .wr(io_wr), .dev_sel(dev_sel),
    .dev_idx(dev_idx), .dev_rd(dev_rd), .dev_wr(dev_wr), .src(io_src));

  assign dev_arr[0] = disk_rdata;
  assign dev_arr[1] = ser0_rdata;
  assign dev_arr[2] = ser1_rdata;

  always_comb begin
    dev_rdata = '0;
    for (int g = 0; g < DEV_N; g++)
      if (dev_sel[g]) dev_rdata = dev_rdata | dev_arr[g];
  end

  assign ram_wdata = cpu_wdata;
  assign dev_wdata = cpu_wdata;

  bdec_rd_return u_ret (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .io_rd(io_rd),
    .mem_src(mem_src), .io_src(io_src), .ram_rdata(ram_rdata),
    .rom_rdata(rom_rdata), .sw_hi(sw_in[15:8]), .dev_rdata(dev_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data));

  // R12: no return pulse follows a write-only cycle
  a_r12_no_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past((mem_wr | io_wr) & ~(mem_rd | io_rd)) |-> !rd_valid);
  // R2: a return pulse always has a read strobe one cycle earlier
  a_r2_valid_has_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_rd | io_rd));
  // R5: the ROM page is never written
  a_r5_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && 32'(cpu_addr) >= ROM_BASE) |-> !ram_we);
  // R10: at most one device selected, and none without a port strobe
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel) && ((io_rd | io_wr) || dev_sel == '0));
  // R3: fill byte for reads in the unpopulated gap
  a_r3_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && 32'(cpu_addr) >= RAM_BYTES && 32'(cpu_addr) < ROM_BASE) |=> rd_data == FILL_BYTE);
  // R7: the switch port returns the high switch byte
  a_r7_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && 32'(cpu_addr[7:0]) == SW_PORT) |=> rd_data == $past(sw_in[15:8]));
endmodule

// File: tb/sim_bus_decoder.sv
module sim_bus_decoder;
  localparam int RAM_BYTES = 16384;
  localparam int AW = 14;

  logic clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic mem_rd = 0, mem_wr = 0, io_rd = 0, io_wr = 0;
  logic rd_valid; logic [7:0] rd_data;
  logic [AW-1:0] ram_addr; logic [7:0] ram_wdata; logic ram_we;
  logic [7:0] ram_rdata, rom_addr, rom_rdata;
  logic [15:0] sw_in = 16'hA53C;
  logic [2:0] dev_sel; logic [1:0] dev_idx;
  logic dev_rd, dev_wr; logic [7:0] dev_wdata;
  logic [7:0] disk_rdata, ser0_rdata, ser1_rdata;

  always #10 clk = ~clk;

  // peripheral models: data is a pure function of the address/index
  assign ram_rdata  = ram_addr[7:0] ^ {2'b00, ram_addr[13:8]};
  assign rom_rdata  = rom_addr ^ 8'h3C;
  assign disk_rdata = 8'hD0 | {6'd0, dev_idx};
  assign ser0_rdata = 8'h50 | {6'd0, dev_idx};
  assign ser1_rdata = 8'h60 | {6'd0, dev_idx};

  bus_decoder #(.RAM_BYTES(RAM_BYTES)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every return pulse must match the oldest expected byte
  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_q.size() == 0) check("R12 unexpected rd_valid", 1, 0);
    else begin
      logic [7:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check(t, {24'd0, rd_data}, {24'd0, e});
    end
  end

  task automatic idle();
    @(negedge clk);
    mem_rd = 0; mem_wr = 0; io_rd = 0; io_wr = 0;
  endtask

  task automatic mem_read(logic [15:0] a, logic [7:0] e, string t);
    @(negedge clk); cpu_addr = a; mem_rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    #2 check({t, " no ram_we"}, ram_we, 0);
    idle();
  endtask

  task automatic mem_write(logic [15:0] a, logic [7:0] d, bit we, string t);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; mem_wr = 1;
    #2 check({t, " ram_we"}, ram_we, we);
    if (we) begin
      check({t, " ram_addr"}, ram_addr, a[AW-1:0]);
      check({t, " ram_wdata"}, ram_wdata, d);
    end
    idle();
  endtask

  task automatic io_op(bit rd, logic [7:0] p, logic [2:0] sel, logic [1:0] idx,
                       logic [7:0] e, string t);
    @(negedge clk); cpu_addr = {8'h00, p}; cpu_wdata = 8'h77;
    io_rd = rd; io_wr = !rd;
    if (rd) begin exp_q.push_back(e); tag_q.push_back(t); end
    #2 check({t, " dev_sel"}, dev_sel, sel);
    if (sel != 0) begin
      check({t, " dev_idx"}, dev_idx, idx);
      check({t, " dev strobe"}, {dev_rd, dev_wr}, rd ? 2'b10 : 2'b01);
    end else check({t, " dev strobe idle"}, {dev_rd, dev_wr}, 2'b00);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 dev_sel", dev_sel, 0);
    check("R1 ram_we", ram_we, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", rd_valid, 0);

    mem_read(16'h0000, 8'h00, "R2 ram 0000");
    mem_read(16'h1234, 8'h34 ^ 8'h12, "R2 ram 1234");
    mem_read(16'h3FFF, 8'hFF ^ 8'h3F, "R2 ram top");
    mem_read(16'h4000, 8'hFF, "R3 first missing");
    mem_read(16'hFEFF, 8'hFF, "R3 below rom");
    mem_read(16'hFF00, 8'h00 ^ 8'h3C, "R4 rom first");
    mem_read(16'hFFC5, 8'hC5 ^ 8'h3C, "R4 rom mid");
    mem_write(16'h0100, 8'h5A, 1, "R6 write low");
    mem_write(16'h3FFF, 8'hC3, 1, "R6 write top");
    mem_write(16'h4000, 8'h11, 0, "R6 write missing");
    mem_write(16'hFF10, 8'h22, 0, "R5 write rom");

    sw_in = 16'hA53C;
    io_op(1, 8'hFF, 3'b000, 0, 8'hA5, "R7 switch");
    sw_in = 16'h0F00;
    io_op(1, 8'hFF, 3'b000, 0, 8'h0F, "R7 switch second");
    io_op(1, 8'h00, 3'b000, 0, 8'hFF, "R8 port 0");
    io_op(1, 8'h0B, 3'b000, 0, 8'hFF, "R9 port 11 unmapped");
    io_op(0, 8'hFF, 3'b000, 0, 0, "R8 out switch port");
    io_op(0, 8'h40, 3'b000, 0, 0, "R8 out unmapped");
    io_op(1, 8'h08, 3'b001, 0, 8'hD0, "R9 disk 0");
    io_op(1, 8'h09, 3'b001, 1, 8'hD1, "R9 disk 1");
    io_op(0, 8'h0A, 3'b001, 2, 0, "R9 disk 2 out");
    io_op(1, 8'h10, 3'b010, 0, 8'h50, "R10 ser0 status");
    io_op(0, 8'h11, 3'b010, 1, 0, "R10 ser0 data out");
    io_op(1, 8'h12, 3'b100, 0, 8'h60, "R10 ser1 status");
    io_op(1, 8'h13, 3'b100, 1, 8'h61, "R11 ser1 data in");

    // back-to-back reads: R11 / R2 with no gap
    @(negedge clk); cpu_addr = 16'h0011; io_rd = 1;
    exp_q.push_back(8'h51); tag_q.push_back("R11 b2b ser0");
    @(negedge clk); io_rd = 0; cpu_addr = 16'h0022; mem_rd = 1;
    exp_q.push_back(8'h22); tag_q.push_back("R2 b2b ram");
    idle();
    repeat (3) @(negedge clk);
    check("R12 queue drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule